// File: doc/BRIEF.md
# Slave Serial Configuration Sequencer

This block loads a configuration image into a target device through the target's slave serial port. It takes the image as a byte stream. When started, it drives the program-reset line low for a fixed time and then releases it. It waits for the target to raise its init-ready line. It then shifts every byte out on the data line, one bit per configuration clock pulse. After the last byte it keeps clocking until the target raises its done line.

Every wait has a bound. The run ends in exactly one of two ways. One is a success pulse. The other is a failure pulse carrying a code. The code says whether init never rose, done never rose, or the byte stream flagged a bad byte. A system controller starts a run with a byte count and feeds the stream through a valid/ready handshake. It then watches `busy_o` and the outcome pulses.

Top module: `sscfg_seq`

## Requirements
- R1: After reset the block is idle: `prog_n_o`=1, `cclk_o`=0, `busy_o`=0, `s_ready_o`=0, `success_o`=0, `fail_o`=0, `err_code_o`=0.
- R2: A start in idle drives `prog_n_o` low for exactly PROG_LOW_CYC clock cycles and then high. No clock pulse is made and no byte is accepted before `init_n_i` is seen high.
- R3: `init_n_i` may first be seen high at most INIT_TMO-1 cycles after `prog_n_o` rises, and the run then continues. If it stays low for INIT_TMO cycles, the block makes no clock pulse, pulses `fail_o` with code 1 and returns to idle.
- R4: Each byte is sent most significant bit first. `din_o` is set while `cclk_o` is low and holds while it is high. Each high phase of a data bit lasts HALF_CYC cycles.
- R5: Exactly `byte_count_i` bytes are taken from the stream and shifted, giving 8 clock pulses per byte before trailing clocking starts.
- R6: After the last byte, `cclk_o` keeps toggling until `done_i` is seen high. The block then pulses `success_o` with code 0 and returns to idle.
- R7: If `done_i` is not seen within DONE_TMO trailing pulses, the block pulses `fail_o` with code 2 after the high phase of the last pulse.
- R8: If `done_i` is high in the very cycle that the done timeout expires, the run ends in success.
- R9: A beat accepted with `s_error_i` high aborts the run at once. That beat is not shifted, and `fail_o` pulses with code 3.
- R10: `start_i` is ignored while `busy_o` is high. The running download keeps its byte count and data.
- R11: A byte count of 0 goes from the init wait straight to trailing clocking.
- R12: `err_code_o` holds the last outcome until the next accepted start, which clears it to 0. `busy_o` falls in the same cycle that an outcome pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a download (ignored while busy) |
| byte_count_i | input | CNT_W | Number of image bytes to send |
| s_data_i | input | 8 | Stream byte |
| s_valid_i | input | 1 | Stream byte valid |
| s_error_i | input | 1 | Stream byte flagged bad |
| s_ready_o | output | 1 | Block takes the stream byte this cycle |
| prog_n_o | output | 1 | Program-reset line to target, active low |
| cclk_o | output | 1 | Configuration clock to target |
| din_o | output | 1 | Serial data to target |
| init_n_i | input | 1 | Target init-ready line |
| done_i | input | 1 | Target done line |
| busy_o | output | 1 | Download in progress |
| success_o | output | 1 | One-cycle success pulse |
| fail_o | output | 1 | One-cycle failure pulse |
| err_code_o | output | 2 | Outcome code: 0 none, 1 init, 2 done, 3 stream |

## Verification
The done check and the done timeout can land in the same cycle. This happens at the end of the high phase of the last allowed trailing pulse. The bench's target model counts clock pulses and raises done exactly one cycle after that final rising edge, so it is seen in the closing cycle of that phase. The run must then end in success. A second run raises done one cycle later and must end with code 2, which shows where the boundary lies. The init wait is probed the same way, at the last allowed cycle and one past it.

// File: rtl/sscfg_seq.sv
module sscfg_seq #(
  parameter int CNT_W        = 16,
  parameter int PROG_LOW_CYC = 4,
  parameter int HALF_CYC     = 2,
  parameter int INIT_TMO     = 40,
  parameter int DONE_TMO     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] byte_count_i,
  input  logic [7:0]       s_data_i,
  input  logic             s_valid_i,
  input  logic             s_error_i,
  output logic             s_ready_o,
  output logic             prog_n_o,
  output logic             cclk_o,
  output logic             din_o,
  input  logic             init_n_i,
  input  logic             done_i,
  output logic             busy_o,
  output logic             success_o,
  output logic             fail_o,
  output logic [1:0]       err_code_o
);

  localparam int TMR_MAX0 = (PROG_LOW_CYC > HALF_CYC) ? PROG_LOW_CYC : HALF_CYC;
  localparam int TMR_MAX  = (TMR_MAX0 > INIT_TMO) ? TMR_MAX0 : INIT_TMO;
  localparam int TMR_W    = $clog2(TMR_MAX + 1);
  localparam int PC_W     = $clog2(DONE_TMO + 1);

  localparam logic [TMR_W-1:0] PROG_END = TMR_W'(PROG_LOW_CYC - 1);
  localparam logic [TMR_W-1:0] HALF_END = TMR_W'(HALF_CYC - 1);
  localparam logic [TMR_W-1:0] INIT_END = TMR_W'(INIT_TMO - 1);
  localparam logic [PC_W-1:0]  DONE_END = PC_W'(DONE_TMO - 1);

  localparam logic [1:0] CODE_OK     = 2'd0;
  localparam logic [1:0] CODE_INIT   = 2'd1;
  localparam logic [1:0] CODE_DONE   = 2'd2;
  localparam logic [1:0] CODE_STREAM = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PROG, ST_WAIT_INIT, ST_FETCH,
    ST_BIT_LO, ST_BIT_HI, ST_TRAIL_LO, ST_TRAIL_HI
  } state_t;

  state_t           state;
  logic [TMR_W-1:0] tmr;
  logic [PC_W-1:0]  pulses;
  logic [2:0]       bit_idx;
  logic [7:0]       shreg;
  logic [CNT_W-1:0] remain;

  wire half_done = (tmr == HALF_END);

  assign prog_n_o  = (state != ST_PROG);
  assign cclk_o    = (state == ST_BIT_HI) || (state == ST_TRAIL_HI);
  assign din_o     = shreg[7];
  assign s_ready_o = (state == ST_FETCH);
  assign busy_o    = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      tmr        <= '0;
      pulses     <= '0;
      bit_idx    <= '0;
      shreg      <= '0;
      remain     <= '0;
      success_o  <= 1'b0;
      fail_o     <= 1'b0;
      err_code_o <= CODE_OK;
    end else begin
      success_o <= 1'b0;
      fail_o    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            remain     <= byte_count_i;
            tmr        <= '0;
            err_code_o <= CODE_OK;
            state      <= ST_PROG;
          end
        end
        ST_PROG: begin
          if (tmr == PROG_END) begin
            tmr   <= '0;
            state <= ST_WAIT_INIT;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_WAIT_INIT: begin
          if (init_n_i) begin
            tmr    <= '0;
            pulses <= '0;
            state  <= (remain == '0) ? ST_TRAIL_LO : ST_FETCH;
          end else if (tmr == INIT_END) begin
            fail_o     <= 1'b1;
            err_code_o <= CODE_INIT;
            state      <= ST_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_FETCH: begin
          if (s_valid_i) begin
            if (s_error_i) begin
              fail_o     <= 1'b1;
              err_code_o <= CODE_STREAM;
              state      <= ST_IDLE;
            end else begin
              shreg   <= s_data_i;
              bit_idx <= '0;
              tmr     <= '0;
              state   <= ST_BIT_LO;
            end
          end
        end
        ST_BIT_LO: begin
          if (half_done) begin
            tmr   <= '0;
            state <= ST_BIT_HI;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_BIT_HI: begin
          if (half_done) begin
            tmr <= '0;
            if (bit_idx == 3'd7) begin
              remain <= remain - 1'b1;
              pulses <= '0;
              state  <= (remain == CNT_W'(1)) ? ST_TRAIL_LO : ST_FETCH;
            end else begin
              bit_idx <= bit_idx + 1'b1;
              shreg   <= {shreg[6:0], 1'b0};
              state   <= ST_BIT_LO;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_TRAIL_LO: begin
          if (done_i) begin
            success_o <= 1'b1;
            state     <= ST_IDLE;
          end else if (half_done) begin
            tmr   <= '0;
            state <= ST_TRAIL_HI;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_TRAIL_HI: begin
          if (done_i) begin
            success_o <= 1'b1;
            state     <= ST_IDLE;
          end else if (half_done) begin
            tmr <= '0;
            if (pulses == DONE_END) begin
              fail_o     <= 1'b1;
              err_code_o <= CODE_DONE;
              state      <= ST_IDLE;
            end else begin
              pulses <= pulses + 1'b1;
              state  <= ST_TRAIL_LO;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sscfg_seq_chk.sv
module sscfg_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       s_ready_o,
  input logic       prog_n_o,
  input logic       cclk_o,
  input logic       din_o,
  input logic       busy_o,
  input logic       success_o,
  input logic       fail_o,
  input logic [1:0] err_code_o
);

  assert_quiet_in_prog_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n_o |-> (!cclk_o && !s_ready_o));

  assert_din_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cclk_o && $past(cclk_o)) |-> $stable(din_o));

  assert_one_outcome_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(success_o && fail_o));

  assert_ok_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    success_o |-> (err_code_o == 2'd0));

  assert_fail_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> (err_code_o != 2'd0));

  assert_end_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (success_o || fail_o));

  assert_no_pulse_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (success_o || fail_o) |-> !busy_o);

endmodule

bind sscfg_seq sscfg_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .s_ready_o(s_ready_o), .prog_n_o(prog_n_o),
  .cclk_o(cclk_o), .din_o(din_o), .busy_o(busy_o), .success_o(success_o),
  .fail_o(fail_o), .err_code_o(err_code_o)
);

// File: tb/sscfg_seq_test.sv
module sscfg_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int PLOW  = 4;
  localparam int HALF  = 2;
  localparam int ITMO  = 40;
  localparam int DTMO  = 16;

  logic clk = 0, rst_n = 0;
  logic start = 0;
  logic [CNT_W-1:0] byte_count = '0;
  logic [7:0] s_data = '0;
  logic s_valid = 0, s_error = 0, s_ready;
  logic prog_n, cclk, din, busy, success, fail;
  logic init_n = 1, done = 0;
  logic [1:0] err_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  sscfg_seq #(.CNT_W(CNT_W), .PROG_LOW_CYC(PLOW), .HALF_CYC(HALF),
              .INIT_TMO(ITMO), .DONE_TMO(DTMO)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .byte_count_i(byte_count),
    .s_data_i(s_data), .s_valid_i(s_valid), .s_error_i(s_error),
    .s_ready_o(s_ready), .prog_n_o(prog_n), .cclk_o(cclk), .din_o(din),
    .init_n_i(init_n), .done_i(done), .busy_o(busy), .success_o(success),
    .fail_o(fail), .err_code_o(err_code));

  int checks = 0, failures = 0;
  bit finished = 0;

  // scoreboard and target model state
  logic [7:0] exp_q[$];
  int init_delay = 0, initc = 0; bit init_arm = 0;
  int done_target = -1, done_lag = 0, lagc = 0; bit done_arm = 0;
  int rises = 0, plow = 0, bitc = 0, hi_run = 0; bit hi_data = 0, prev_cclk = 0;
  logic [7:0] acc = '0;
  bit got_succ = 0, got_fail = 0; logic [1:0] got_code = '0;
  int src_n = 0, src_idx = 0, src_err = -1, beats = 0; bit acc_pend = 0;

  function automatic logic [7:0] byte_of(input int i);
    return 8'((i * 53 + 8'hA5) ^ (i << 3));
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // stream source
  initial forever begin
    @(negedge clk);
    if (acc_pend) begin acc_pend = 0; src_idx++; beats++; end
    s_valid = (src_idx < src_n);
    s_data  = byte_of(src_idx);
    s_error = (src_idx == src_err);
    if (s_ready && s_valid) acc_pend = 1;
  end

  // monitor: target model plus scoreboard
  initial forever begin
    @(negedge clk);
    if (!prog_n) begin
      plow++; init_n = 0; init_arm = 1; initc = init_delay;
    end else if (init_arm && init_delay >= 0) begin
      if (initc == 0) begin init_n = 1; init_arm = 0; end
      else initc--;
    end
    if (cclk && !prev_cclk) begin
      rises++; hi_run = 0;
      if (exp_q.size() > 0) begin
        hi_data = 1;
        acc = {acc[6:0], din};
        bitc++;
        if (bitc == 8) begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(acc == e, "R4", "byte MSB-first", int'(acc), int'(e));
          bitc = 0;
        end
      end else hi_data = 0;
      if (done_target >= 0 && rises == done_target) begin done_arm = 1; lagc = done_lag; end
    end
    if (cclk) hi_run++;
    if (!cclk && prev_cclk && hi_data)
      chk(hi_run == HALF, "R4", "data high phase length", hi_run, HALF);
    if (done_arm) begin
      if (lagc == 0) begin done = 1; done_arm = 0; end
      else lagc--;
    end
    if (success) got_succ = 1;
    if (fail) begin got_fail = 1; got_code = err_code; end
    prev_cclk = cclk;
  end

  task automatic run_dl(input int n, input int idelay, input int dtarget, input int dlag,
                        input int err_idx, input int poke_at, input int exp_code,
                        input int exp_rises, input int exp_beats, input string req);
    int nexp, cyc;
    nexp = (exp_code == 1) ? 0 : ((err_idx >= 0) ? err_idx : n);
    for (int i = 0; i < nexp; i++) exp_q.push_back(byte_of(i));
    init_delay = idelay; done = 0; done_arm = 0;
    done_target = (dtarget >= 0) ? 8 * n + dtarget : -1; done_lag = dlag;
    rises = 0; plow = 0; bitc = 0; got_succ = 0; got_fail = 0;
    src_n = n; src_idx = 0; src_err = err_idx; beats = 0; acc_pend = 0;
    byte_count = CNT_W'(n); start = 1;
    @(negedge clk);
    start = 0;
    chk(busy && err_code == 0, "R12", "start clears code / busy", int'(err_code), 0);
    cyc = 0;
    while (busy && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (cyc == poke_at) begin start = 1; byte_count = CNT_W'(7); end
      else start = 0;
    end
    start = 0;
    @(negedge clk);
    chk(plow == PLOW, "R2", {req, " program low width"}, plow, PLOW);
    if (exp_code == 0)
      chk(got_succ && !got_fail, "R6", {req, " success outcome"}, int'(got_fail), 0);
    else
      chk(got_fail && !got_succ && got_code == 2'(exp_code), req, "failure code",
          int'(got_code), exp_code);
    chk(err_code == 2'(exp_code), "R12", {req, " held code"}, int'(err_code), exp_code);
    chk(rises == exp_rises, "R5", {req, " clock pulse count"}, rises, exp_rises);
    chk(beats == exp_beats, "R5", {req, " stream beats"}, beats, exp_beats);
    chk(exp_q.size() == 0, "R5", {req, " bytes left in scoreboard"}, exp_q.size(), 0);
    chk(prog_n && !cclk && !busy, "R6", {req, " idle after run"}, int'(busy), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(prog_n && !cclk && !busy && !s_ready && !success && !fail && err_code == 0,
        "R1", "outputs in reset", int'(busy), 0);
    rst_n = 1;
    @(negedge clk);
    chk(prog_n && !cclk && !busy && !s_ready && err_code == 0, "R1", "idle after reset",
        int'(busy), 0);

    // n, idelay, dtarget, dlag, err_idx, poke, code, rises, beats
    run_dl(4, 3, 2, 0, -1, 0, 0, 34, 4, "R6");
    run_dl(0, 0, 3, 0, -1, 0, 0, 3, 0, "R11");
    run_dl(2, ITMO - 1, 1, 0, -1, 0, 0, 17, 2, "R3");
    run_dl(2, ITMO, 1, 0, -1, 0, 1, 0, 0, "R3");
    repeat (5) @(negedge clk);
    chk(err_code == 2'd1, "R12", "code held while idle", int'(err_code), 1);
    run_dl(2, 1, -1, 0, -1, 0, 2, 16 + DTMO, 2, "R7");
    run_dl(1, 1, DTMO, 1, -1, 0, 0, 8 + DTMO, 1, "R8");
    run_dl(1, 1, DTMO, 2, -1, 0, 2, 8 + DTMO, 1, "R8");
    run_dl(5, 2, 2, 0, 2, 0, 3, 16, 3, "R9");
    run_dl(3, 1, 2, 0, -1, 20, 0, 26, 3, "R10");

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule